// File: doc/BRIEF.md
# Bus-Width-Adapting Communication Buffer

This block sits between a shared system bus and a processing IP. It holds one block of data in each direction. The receive half stores a block arriving from the bus until the IP has worked on it. The transmit half stores the IP's results until they have left on the bus. Each half is built from parallel single-port memory banks. When an item is narrower than the bus, the bus word is split into lanes: one bank per lane, with every lane of a beat written in the same clock. A bus that is twice the item width therefore moves two items per cycle, and a four-times-wider bus moves four. When an item is wider than the bus, the block gathers several consecutive beats in a staging register and then performs a single bank write.

Ordering between the three activities is enforced per buffer. The IP may read received data only once the whole block has arrived, which is signalled by `rx_full`. The bus cannot refill the receive buffer until the IP releases it. The IP cannot write new results into the transmit buffer until its previous contents have gone out on the bus, which is signalled by `tx_empty`. The block length in items comes from `blk_items`. A last, partial bus beat is marked by a per-lane item mask.

Top module: `bwb_buffer`

## Requirements
- R1: After reset, `bus_in_ready` is 1, `rx_full` is 0, `tx_empty` is 1 and `bus_out_valid` is 0.
- R2: When the item is narrower than the bus, lane l is bits [l*DATA_W +: DATA_W] of the bus word, with lane 0 in the least significant bits. The lane of receive beat b is stored as item address b*LANES+l. All lanes of one beat are stored in the cycle the beat is accepted, and one beat is accepted per cycle.
- R3: `rx_full` rises in the cycle after the accepted beat that brings the stored item count up to `blk_items`, or that fills the last word row. While `rx_full` is 1, `bus_in_ready` is 0.
- R4: A lane whose bit in `bus_in_mask` is 0 is neither written nor counted toward the block length. The bank word at that lane keeps its earlier content.
- R5: A read request (`ip_rx_rd_en` with `ip_rx_addr`) made while `rx_full` is 1 returns the item on `ip_rx_data` one cycle later.
- R6: `ip_rx_release` while `rx_full` is 1 clears `rx_full` and raises `bus_in_ready` in the next cycle. The next block is stored again from item address 0.
- R7: Each bank is single-port and never reads and writes in the same cycle. An IP read requested while the receive buffer is still filling is ignored and does not disturb the fill.
- R8: While `tx_empty` is 1, `ip_tx_wr_en` stores `ip_tx_data` at item address `ip_tx_addr`. A pulse on `ip_tx_send` with a non-zero `blk_items` drops `tx_empty` in the next cycle. `tx_empty` stays 0 until the last beat has been accepted.
- R9: The first transmit beat becomes valid two cycles after the send pulse, because the bank read adds one cycle of latency. Beat r carries item r*LANES+l in lane l.
- R10: While `bus_out_valid` is 1 and `bus_out_ready` is 0, the beat, its data and its mask stay unchanged.
- R11: IP writes into the transmit buffer while it is sending are ignored.
- R12: Bit l of `bus_out_mask` is 1 exactly when item r*LANES+l lies below the block length captured at the send. A send pulse while `blk_items` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_items | input | $clog2(CAP+1) | Block length in items |
| bus_in_valid | input | 1 | Receive beat offered by the bus |
| bus_in_ready | output | 1 | Receive buffer accepts a beat |
| bus_in_data | input | BUS_W | Receive beat data |
| bus_in_mask | input | LANES | Per-lane item-valid mask |
| rx_full | output | 1 | Whole receive block present |
| ip_rx_rd_en | input | 1 | IP read request |
| ip_rx_addr | input | $clog2(CAP) | IP read item address |
| ip_rx_data | output | DATA_W | Read item, one cycle after request |
| ip_rx_release | input | 1 | IP has consumed the receive block |
| tx_empty | output | 1 | Transmit buffer may be written |
| ip_tx_wr_en | input | 1 | IP write strobe |
| ip_tx_addr | input | $clog2(CAP) | IP write item address |
| ip_tx_data | input | DATA_W | IP write item |
| ip_tx_send | input | 1 | Start sending the transmit block |
| bus_out_valid | output | 1 | Transmit beat valid |
| bus_out_ready | input | 1 | Bus takes the transmit beat |
| bus_out_data | output | BUS_W | Transmit beat data |
| bus_out_mask | output | LANES | Lanes carrying items in the beat |

## Verification
A receive beat that completes the block shows as `rx_full` high at the first falling edge after the accepting rising edge. A read returns data at the falling edge one rising edge after the request. A release shows as `bus_in_ready` high one edge later. On the transmit side, `tx_empty` falls one edge after the send pulse and the first beat is valid two edges after it. The bench therefore drives every input on a falling edge and samples at exactly those falling edges. It tracks receive-memory contents in its own model, so that masked lanes are checked against the earlier block's values. While the transmit buffer sends, it varies `bus_out_ready` with an arithmetic pattern, checks that held beats stay unchanged, and tries garbage writes on every cycle.

// File: rtl/bwb_pkg.sv
package bwb_pkg;
  // lanes per bus word when the item is no wider than the bus
  function automatic int lanes_f(int bus_w, int data_w);
    return (bus_w > data_w) ? bus_w / data_w : 1;
  endfunction

  // bus beats per item when the item is wider than the bus
  function automatic int beats_f(int bus_w, int data_w);
    return (data_w > bus_w) ? data_w / bus_w : 1;
  endfunction

  function automatic int clog2_min1(int v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction

  // word rows needed to hold a number of items
  function automatic int rows_for(int items, int lanes);
    return (items + lanes - 1) / lanes;
  endfunction
endpackage

// File: rtl/bwb_bank.sv
module bwb_bank #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  parameter int AW    = 2
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // one port: a write or a read per enabled cycle
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/bwb_rx_side.sv
module bwb_rx_side
  import bwb_pkg::*;
#(
  parameter int BUS_W       = 32,
  parameter int DATA_W      = 8,
  parameter int DEPTH_WORDS = 4,
  parameter int LANES       = 4,
  parameter int BPI         = 1,
  parameter int ROW_W       = 32,
  parameter int RW          = 2,
  parameter int IAW         = 4,
  parameter int CW          = 5,
  parameter int LW          = 2,
  parameter int BBW         = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    blk_items,
  input  logic             bus_in_valid,
  input  logic [BUS_W-1:0] bus_in_data,
  input  logic [LANES-1:0] bus_in_mask,
  output logic             bus_in_ready,
  input  logic             ip_rx_rd_en,
  input  logic [IAW-1:0]   ip_rx_addr,
  input  logic             ip_rx_release,
  output logic [DATA_W-1:0] ip_rx_data,
  output logic             rx_full,
  output logic [LANES-1:0] bank_we,
  output logic [LANES-1:0] bank_re,
  output logic [RW-1:0]    bank_row,
  output logic [ROW_W-1:0] bank_wdata,
  input  logic [ROW_W-1:0] bank_rdata
);
  logic             full_q;
  logic [CW-1:0]    count_q;
  logic [CW-1:0]    count_nx;
  logic [RW-1:0]    row_q;
  logic [BBW-1:0]   beat_q;
  logic [ROW_W-1:0] stage_q;
  logic [LW-1:0]    lsel_q;
  logic [LW-1:0]    rd_lane;
  logic [RW-1:0]    rd_row;
  logic             fire, last_beat, row_end, done_nx, rd_fire;

  assign fire      = bus_in_valid && !full_q;
  assign last_beat = (int'(beat_q) == BPI - 1);
  assign row_end   = fire && last_beat;
  assign count_nx  = count_q + CW'($countones(bus_in_mask));
  assign done_nx   = (int'(count_nx) >= int'(blk_items)) ||
                     (int'(row_q) == DEPTH_WORDS - 1);
  assign rd_fire   = full_q && ip_rx_rd_en;
  assign rd_lane   = LW'(int'(ip_rx_addr) % LANES);
  assign rd_row    = RW'(int'(ip_rx_addr) / LANES);

  // merge the current beat into the staged row
  always_comb begin
    bank_wdata = stage_q;
    bank_wdata[int'(beat_q)*BUS_W +: BUS_W] = bus_in_data;
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      bank_we[l] = row_end && bus_in_mask[l];
      bank_re[l] = rd_fire && (int'(rd_lane) == l);
    end
  end

  assign bank_row     = full_q ? rd_row : row_q;
  assign bus_in_ready = !full_q;
  assign rx_full      = full_q;
  assign ip_rx_data   = bank_rdata[int'(lsel_q)*DATA_W +: DATA_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      count_q <= '0;
      row_q   <= '0;
      beat_q  <= '0;
      stage_q <= '0;
      lsel_q  <= '0;
    end else begin
      if (full_q) begin
        if (ip_rx_release) begin
          full_q  <= 1'b0;
          count_q <= '0;
          row_q   <= '0;
          beat_q  <= '0;
        end
      end else if (fire) begin
        if (last_beat) begin
          beat_q  <= '0;
          count_q <= count_nx;
          if (done_nx) full_q <= 1'b1;
          else         row_q  <= row_q + 1'b1;
        end else begin
          beat_q  <= beat_q + 1'b1;
          stage_q <= bank_wdata;
        end
      end
      if (rd_fire) lsel_q <= rd_lane;
    end
  end
endmodule

// File: rtl/bwb_tx_side.sv
module bwb_tx_side
  import bwb_pkg::*;
#(
  parameter int BUS_W       = 32,
  parameter int DATA_W      = 8,
  parameter int DEPTH_WORDS = 4,
  parameter int LANES       = 4,
  parameter int BPI         = 1,
  parameter int ROW_W       = 32,
  parameter int RW          = 2,
  parameter int RCW         = 3,
  parameter int IAW         = 4,
  parameter int CW          = 5,
  parameter int BBW         = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     blk_items,
  input  logic              ip_tx_wr_en,
  input  logic [IAW-1:0]    ip_tx_addr,
  input  logic [DATA_W-1:0] ip_tx_data,
  input  logic              ip_tx_send,
  output logic              tx_empty,
  input  logic              bus_out_ready,
  output logic              bus_out_valid,
  output logic [BUS_W-1:0]  bus_out_data,
  output logic [LANES-1:0]  bus_out_mask,
  output logic [LANES-1:0]  bank_we,
  output logic [LANES-1:0]  bank_re,
  output logic [RW-1:0]     bank_row,
  output logic [ROW_W-1:0]  bank_wdata,
  input  logic [ROW_W-1:0]  bank_rdata,
  output logic              issue
);
  localparam int CAP = DEPTH_WORDS * LANES;

  logic           send_q, ovalid_q;
  logic [CW-1:0]  items_q;
  logic [RCW-1:0] rows_q, rd_row_q, orow_q;
  logic [BBW-1:0] beat_q;
  logic           wr_fire, last_beat, beat_acc, row_done, can_load, final_beat;
  int             eff_items;

  assign eff_items  = (int'(blk_items) > CAP) ? CAP : int'(blk_items);
  assign wr_fire    = !send_q && ip_tx_wr_en;
  assign last_beat  = (int'(beat_q) == BPI - 1);
  assign beat_acc   = ovalid_q && bus_out_ready;
  assign row_done   = beat_acc && last_beat;
  assign can_load   = !ovalid_q || row_done;
  assign issue      = send_q && (int'(rd_row_q) < int'(rows_q)) && can_load;
  assign final_beat = row_done && (int'(orow_q) == int'(rows_q) - 1);

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      bank_we[l] = wr_fire && ((int'(ip_tx_addr) % LANES) == l);
      bank_re[l] = issue;
      bus_out_mask[l] = (int'(orow_q) * LANES + l) < int'(items_q);
    end
  end

  assign bank_wdata    = {LANES{ip_tx_data}};
  assign bank_row      = send_q ? rd_row_q[RW-1:0] : RW'(int'(ip_tx_addr) / LANES);
  assign bus_out_data  = bank_rdata[int'(beat_q)*BUS_W +: BUS_W];
  assign bus_out_valid = ovalid_q;
  assign tx_empty      = !send_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      send_q   <= 1'b0;
      ovalid_q <= 1'b0;
      items_q  <= '0;
      rows_q   <= '0;
      rd_row_q <= '0;
      orow_q   <= '0;
      beat_q   <= '0;
    end else if (!send_q) begin
      if (ip_tx_send && eff_items != 0) begin
        send_q   <= 1'b1;
        items_q  <= CW'(eff_items);
        rows_q   <= RCW'(rows_for(eff_items, LANES));
        rd_row_q <= '0;
      end
      ovalid_q <= 1'b0;
    end else begin
      if (issue) begin
        rd_row_q <= rd_row_q + 1'b1;
        orow_q   <= rd_row_q;
        ovalid_q <= 1'b1;
        beat_q   <= '0;
      end else if (row_done) begin
        ovalid_q <= 1'b0;
      end else if (beat_acc) begin
        beat_q <= beat_q + 1'b1;
      end
      if (final_beat) begin
        send_q   <= 1'b0;
        ovalid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bwb_buffer.sv
module bwb_buffer
  import bwb_pkg::*;
#(
  parameter int BUS_W       = 32,
  parameter int DATA_W      = 8,
  parameter int DEPTH_WORDS = 4,
  localparam int LANES = lanes_f(BUS_W, DATA_W),
  localparam int CAP   = DEPTH_WORDS * LANES,
  localparam int IAW   = clog2_min1(CAP),
  localparam int CW    = $clog2(CAP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     blk_items,
  input  logic              bus_in_valid,
  output logic              bus_in_ready,
  input  logic [BUS_W-1:0]  bus_in_data,
  input  logic [LANES-1:0]  bus_in_mask,
  output logic              rx_full,
  input  logic              ip_rx_rd_en,
  input  logic [IAW-1:0]    ip_rx_addr,
  output logic [DATA_W-1:0] ip_rx_data,
  input  logic              ip_rx_release,
  output logic              tx_empty,
  input  logic              ip_tx_wr_en,
  input  logic [IAW-1:0]    ip_tx_addr,
  input  logic [DATA_W-1:0] ip_tx_data,
  input  logic              ip_tx_send,
  output logic              bus_out_valid,
  input  logic              bus_out_ready,
  output logic [BUS_W-1:0]  bus_out_data,
  output logic [LANES-1:0]  bus_out_mask
);
  localparam int BPI   = beats_f(BUS_W, DATA_W);
  localparam int ROW_W = LANES * DATA_W;
  localparam int RW    = clog2_min1(DEPTH_WORDS);
  localparam int RCW   = $clog2(DEPTH_WORDS + 1);
  localparam int LW    = clog2_min1(LANES);
  localparam int BBW   = clog2_min1(BPI);

  // named internal events, observed by the bound checker
  logic [LANES-1:0] rx_bank_we, rx_bank_re, tx_bank_we, tx_bank_re;
  logic [RW-1:0]    rx_row, tx_row;
  logic [ROW_W-1:0] rx_wdata, rx_rdata, tx_wdata, tx_rdata;
  logic             tx_issue;

  bwb_rx_side #(
    .BUS_W(BUS_W), .DATA_W(DATA_W), .DEPTH_WORDS(DEPTH_WORDS), .LANES(LANES),
    .BPI(BPI), .ROW_W(ROW_W), .RW(RW), .IAW(IAW), .CW(CW), .LW(LW), .BBW(BBW)
  ) rx_i (
    .clk(clk), .rst_n(rst_n), .blk_items(blk_items),
    .bus_in_valid(bus_in_valid), .bus_in_data(bus_in_data),
    .bus_in_mask(bus_in_mask), .bus_in_ready(bus_in_ready),
    .ip_rx_rd_en(ip_rx_rd_en), .ip_rx_addr(ip_rx_addr),
    .ip_rx_release(ip_rx_release), .ip_rx_data(ip_rx_data),
    .rx_full(rx_full), .bank_we(rx_bank_we), .bank_re(rx_bank_re),
    .bank_row(rx_row), .bank_wdata(rx_wdata), .bank_rdata(rx_rdata)
  );

  bwb_tx_side #(
    .BUS_W(BUS_W), .DATA_W(DATA_W), .DEPTH_WORDS(DEPTH_WORDS), .LANES(LANES),
    .BPI(BPI), .ROW_W(ROW_W), .RW(RW), .RCW(RCW), .IAW(IAW), .CW(CW), .BBW(BBW)
  ) tx_i (
    .clk(clk), .rst_n(rst_n), .blk_items(blk_items),
    .ip_tx_wr_en(ip_tx_wr_en), .ip_tx_addr(ip_tx_addr),
    .ip_tx_data(ip_tx_data), .ip_tx_send(ip_tx_send), .tx_empty(tx_empty),
    .bus_out_ready(bus_out_ready), .bus_out_valid(bus_out_valid),
    .bus_out_data(bus_out_data), .bus_out_mask(bus_out_mask),
    .bank_we(tx_bank_we), .bank_re(tx_bank_re), .bank_row(tx_row),
    .bank_wdata(tx_wdata), .bank_rdata(tx_rdata), .issue(tx_issue)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    bwb_bank #(.W(DATA_W), .DEPTH(DEPTH_WORDS), .AW(RW)) rx_bank_i (
      .clk(clk), .en(rx_bank_we[l] | rx_bank_re[l]), .we(rx_bank_we[l]),
      .addr(rx_row), .wdata(rx_wdata[l*DATA_W +: DATA_W]),
      .rdata(rx_rdata[l*DATA_W +: DATA_W])
    );
    bwb_bank #(.W(DATA_W), .DEPTH(DEPTH_WORDS), .AW(RW)) tx_bank_i (
      .clk(clk), .en(tx_bank_we[l] | tx_bank_re[l]), .we(tx_bank_we[l]),
      .addr(tx_row), .wdata(tx_wdata[l*DATA_W +: DATA_W]),
      .rdata(tx_rdata[l*DATA_W +: DATA_W])
    );
  end
endmodule

// File: rtl/bwb_buffer_chk.sv
module bwb_buffer_chk #(
  parameter int LANES = 4,
  parameter int BUS_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_full,
  input logic             bus_in_valid,
  input logic             bus_in_ready,
  input logic             tx_empty,
  input logic             bus_out_valid,
  input logic             bus_out_ready,
  input logic [BUS_W-1:0] bus_out_data,
  input logic [LANES-1:0] bus_out_mask,
  input logic [LANES-1:0] rx_bank_we,
  input logic [LANES-1:0] rx_bank_re,
  input logic [LANES-1:0] tx_bank_we,
  input logic [LANES-1:0] tx_bank_re,
  input logic             tx_issue
);
  assert_rx_single_port_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_bank_we & rx_bank_re) == '0);
  assert_tx_single_port_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_bank_we & tx_bank_re) == '0);
  assert_no_rx_write_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> rx_bank_we == '0);
  assert_no_accept_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> !bus_in_ready);
  assert_full_follows_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(bus_in_valid && bus_in_ready));
  assert_read_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_issue |=> bus_out_valid);
  assert_hold_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_out_valid && !bus_out_ready |=>
      bus_out_valid && $stable(bus_out_data) && $stable(bus_out_mask));
  assert_no_tx_write_sending_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_empty |-> tx_bank_we == '0);
  assert_lane0_mask_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_out_valid |-> bus_out_mask[0]);
endmodule

bind bwb_buffer bwb_buffer_chk #(.LANES(LANES), .BUS_W(BUS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_full(rx_full), .bus_in_valid(bus_in_valid),
  .bus_in_ready(bus_in_ready), .tx_empty(tx_empty),
  .bus_out_valid(bus_out_valid), .bus_out_ready(bus_out_ready),
  .bus_out_data(bus_out_data), .bus_out_mask(bus_out_mask),
  .rx_bank_we(rx_bank_we), .rx_bank_re(rx_bank_re),
  .tx_bank_we(tx_bank_we), .tx_bank_re(tx_bank_re), .tx_issue(tx_issue)
);

// File: tb/bwb_buffer_tb_top.sv
module bwb_buffer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  blk_items = '0;
  logic        bus_in_valid = 1'b0;
  logic        bus_in_ready;
  logic [31:0] bus_in_data = '0;
  logic [3:0]  bus_in_mask = '0;
  logic        rx_full;
  logic        ip_rx_rd_en = 1'b0;
  logic [3:0]  ip_rx_addr = '0;
  logic [7:0]  ip_rx_data;
  logic        ip_rx_release = 1'b0;
  logic        tx_empty;
  logic        ip_tx_wr_en = 1'b0;
  logic [3:0]  ip_tx_addr = '0;
  logic [7:0]  ip_tx_data = '0;
  logic        ip_tx_send = 1'b0;
  logic        bus_out_valid;
  logic        bus_out_ready = 1'b0;
  logic [31:0] bus_out_data;
  logic [3:0]  bus_out_mask;

  always #10 clk = ~clk;  // 50 MHz

  bwb_buffer #(.BUS_W(32), .DATA_W(8), .DEPTH_WORDS(4)) dut_i (.*);

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 1'b0;
  logic [7:0] rx_model [16];
  bit         rx_known [16];

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rx_val(int blk, int i);
    return 8'((i * 37 + blk * 11 + 5) & 255);
  endfunction

  function automatic logic [7:0] tx_val(int n, int i);
    return 8'((i * 5 + n * 3) & 127);
  endfunction

  // half=1 puts two items per beat (lanes 0,1) to exercise the mask
  task automatic rx_block(int n, int blk, bit half);
    int per   = half ? 2 : 4;
    int beats = (n + per - 1) / per;
    int idx   = 0;
    blk_items = 5'(n);
    for (int b = 0; b < beats; b++) begin
      logic [3:0] m = '0;
      for (int l = 0; l < 4; l++) begin
        if (l < per && idx < n) begin
          m[l] = 1'b1;
          bus_in_data[l*8 +: 8] = rx_val(blk, idx);
          rx_model[b*4+l] = rx_val(blk, idx);
          rx_known[b*4+l] = 1'b1;
          idx++;
        end else begin
          bus_in_data[l*8 +: 8] = 8'hA5;
        end
      end
      bus_in_mask  = m;
      bus_in_valid = 1'b1;
      ip_rx_rd_en  = 1'b1;  // ignored while filling (R7)
      ip_rx_addr   = 4'(b);
      @(negedge clk);
      check(rx_full == (b == beats - 1), "R3 R7 rx_full timing", 32'(rx_full),
            32'(b == beats - 1));
      check(bus_in_ready == (b != beats - 1), "R3 ready", 32'(bus_in_ready),
            32'(b != beats - 1));
    end
    bus_in_valid = 1'b0;
    ip_rx_rd_en  = 1'b0;
    for (int a = 0; a < 16; a++) begin
      ip_rx_rd_en = 1'b1;
      ip_rx_addr  = 4'(a);
      @(negedge clk);
      if (rx_known[a])
        check(ip_rx_data == rx_model[a], "R2,R5,R4 rx read", 32'(ip_rx_data),
              32'(rx_model[a]));
    end
    ip_rx_rd_en   = 1'b0;
    ip_rx_release = 1'b1;
    @(negedge clk);
    ip_rx_release = 1'b0;
    check(!rx_full && bus_in_ready, "R6 release", {rx_full, bus_in_ready}, 32'b01);
  endtask

  task automatic tx_block(int n);
    int beats = (n + 3) / 4;
    int b = 0;
    int cyc = 0;
    bit hold = 1'b0;
    logic [31:0] pdata = '0;
    logic [3:0]  pmask = '0;
    blk_items = 5'(n);
    for (int i = 0; i < n; i++) begin
      ip_tx_wr_en = 1'b1;
      ip_tx_addr  = 4'(i);
      ip_tx_data  = tx_val(n, i);
      @(negedge clk);
    end
    ip_tx_wr_en = 1'b0;
    check(tx_empty == 1'b1, "R8 empty before send", 32'(tx_empty), 32'd1);
    ip_tx_send = 1'b1;
    @(negedge clk);
    ip_tx_send = 1'b0;
    check(!tx_empty && !bus_out_valid, "R8 R9 send start",
          {tx_empty, bus_out_valid}, 32'b00);
    @(negedge clk);
    while (b < beats && cyc < 200) begin
      logic rdy;
      if (cyc == 0) check(bus_out_valid, "R9 first beat latency", 32'(bus_out_valid), 32'd1);
      if (hold)
        check(bus_out_valid && bus_out_data == pdata && bus_out_mask == pmask,
              "R10 hold", bus_out_data, pdata);
      rdy = ((cyc * 7 + n) % 3) != 0;
      bus_out_ready = rdy;
      ip_tx_wr_en   = 1'b1;  // must be ignored while sending (R11)
      ip_tx_addr    = 4'(cyc % 16);
      ip_tx_data    = 8'hFF;
      hold = 1'b0;
      if (bus_out_valid) begin
        if (rdy) begin
          logic [3:0]  em = '0;
          logic [31:0] ed = '0;
          logic [31:0] bm = '0;
          for (int l = 0; l < 4; l++) begin
            if (b * 4 + l < n) begin
              em[l] = 1'b1;
              ed[l*8 +: 8] = tx_val(n, b * 4 + l);
              bm[l*8 +: 8] = 8'hFF;
            end
          end
          check(bus_out_mask == em, "R12 mask", 32'(bus_out_mask), 32'(em));
          check((bus_out_data & bm) == ed, "R9 R11 beat data", bus_out_data & bm, ed);
          b++;
        end else begin
          hold  = 1'b1;
          pdata = bus_out_data;
          pmask = bus_out_mask;
        end
      end
      @(negedge clk);
      cyc++;
    end
    ip_tx_wr_en   = 1'b0;
    bus_out_ready = 1'b0;
    check(b == beats, "R8 all beats", 32'(b), 32'(beats));
    check(tx_empty && !bus_out_valid, "R8 done", {tx_empty, bus_out_valid}, 32'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_in_ready, "R1 ready", 32'(bus_in_ready), 32'd1);
    check(!rx_full, "R1 rx_full", 32'(rx_full), 32'd0);
    check(tx_empty, "R1 tx_empty", 32'(tx_empty), 32'd1);
    check(!bus_out_valid, "R1 out valid", 32'(bus_out_valid), 32'd0);

    for (int k = 0; k < 16; k++) rx_block((k == 0) ? 16 : k, k, 1'b0);
    rx_block(6, 20, 1'b1);
    rx_block(8, 21, 1'b1);

    for (int n = 1; n <= 16; n++) tx_block(n);

    blk_items  = '0;
    ip_tx_send = 1'b1;
    @(negedge clk);
    ip_tx_send = 1'b0;
    check(tx_empty, "R12 zero-length send ignored", 32'(tx_empty), 32'd1);
    @(negedge clk);
    check(!bus_out_valid, "R12 no beat", 32'(bus_out_valid), 32'd0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule